// File: doc/BRIEF.md
# Receive Message-Object FIFO

This block holds a bank of receive message objects for a CAN controller and makes them behave as a receive FIFO. Each object has its own configuration (valid, chain end, interrupt enable, identifier, mask, mask enable, extended flag), one stored frame, and three status flags: new data, interrupt pending and message lost. When the protocol side hands over a complete frame on a single-cycle strobe, the block picks a destination object and stores the identifier, format, length and payload there. It then raises that object's new-data and interrupt-pending flags.

Objects are searched from index 0 upward. A frame goes into the lowest object that is valid, accepts the identifier and has no unread data. The search stops at the first valid object marked as chain end. If every accepting object up to that point still holds unread data, the chain-end object is overwritten and its lost flag is set. The host polls the new-data bitmap and reads an object through a read-select port. It releases an object with an acknowledge strobe. Because freed low objects are reused first, a slow host can see frames out of arrival order.

Top module: `rxf_fifo`

## Requirements
- R1: After reset all objects are invalid, the new-data, interrupt-pending and lost bitmaps are zero, and `rx_irq` is low.
- R2: An accepted frame is stored in the lowest-index object that is valid, accepts it and has its new-data flag clear. That object's new-data and interrupt-pending bits read 1 on the clock edge after the frame strobe.
- R3: The search ends at the first valid object whose chain-end bit is set. Objects above it never receive a frame while it stays the chain end.
- R4: When no object up to the chain end is free, a frame that the chain-end object accepts overwrites it. The frame sets that object's lost bit, and its new-data bit stays 1.
- R5: An object whose valid bit is 0 is never written and does not end the chain.
- R6: With mask enable set, an object accepts a frame when the identifier bits selected by 1s in its mask equal its configured identifier; a mask of 0 accepts every frame. With mask enable clear, both the identifier and the extended flag must match exactly.
- R7: Bit i of each bitmap belongs to object index i, and object index i is the object numbered i+1.
- R8: A remote frame is stored with `rd_rtr` = 1 and its length code kept, and it reads back with all 64 data bits zero.
- R9: An acknowledge strobe clears new-data, interrupt-pending and lost on the selected object, so the next frame can reuse it ahead of higher objects.
- R10: `rx_irq` is 1 exactly while some object has both its interrupt-pending bit and its interrupt enable set.
- R11: A frame that no object in the chain can take is dropped, and no bitmap changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 4 | Object index being configured |
| cfg_vld | input | 1 | Object valid |
| cfg_eob | input | 1 | Object ends the receive chain |
| cfg_rxie | input | 1 | Receive interrupt enable |
| cfg_umask | input | 1 | Use mask for acceptance |
| cfg_xtd | input | 1 | Configured extended-identifier flag |
| cfg_id | input | 29 | Configured identifier |
| cfg_mask | input | 29 | Acceptance mask, 1 = bit compared |
| frm_valid | input | 1 | Complete frame strobe, one cycle |
| frm_id | input | 29 | Frame identifier |
| frm_xtd | input | 1 | Frame uses an extended identifier |
| frm_rtr | input | 1 | Frame is a remote request |
| frm_dlc | input | 4 | Frame length code |
| frm_data | input | 64 | Frame payload, byte 0 in bits 7:0 |
| ack_we | input | 1 | Host acknowledge strobe |
| ack_sel | input | 4 | Object index being acknowledged |
| rd_sel | input | 4 | Object index shown on the read port |
| rd_id | output | 29 | Stored identifier |
| rd_xtd | output | 1 | Stored extended flag |
| rd_rtr | output | 1 | Stored remote (direction) flag |
| rd_dlc | output | 4 | Stored length code |
| rd_data | output | 64 | Stored payload |
| newdat_map | output | 16 | New-data bit per object |
| intpnd_map | output | 16 | Interrupt-pending bit per object |
| msglost_map | output | 16 | Message-lost bit per object |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
Each strobe (configuration write, frame or acknowledge) is registered on the rising edge that follows it. The bitmaps, `rx_irq` and the stored contents on the read port therefore change one clock edge after the strobe is presented. The bench drives each stimulus just after a rising edge and queues the expected state, stamped with the cycle in which it is due. The monitor takes an entry on the falling edge of that cycle. It sets `rd_sel` to the object that entry names, waits a fraction of a nanosecond and then compares, so the read path and the registered bitmaps are both sampled between edges.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int ID_W   = 29;
  localparam int DLC_W  = 4;
  localparam int DATA_W = 64;

  typedef struct packed {
    logic [ID_W-1:0]   id;
    logic              xtd;
    logic              rtr;
    logic [DLC_W-1:0]  dlc;
    logic [DATA_W-1:0] data;
  } rxf_frame_t;

  typedef struct packed {
    logic            vld;
    logic            eob;
    logic            rxie;
    logic            umask;
    logic            xtd;
    logic [ID_W-1:0] id;
    logic [ID_W-1:0] mask;
  } rxf_cfg_t;
endpackage

// File: rtl/rxf_pick.sv
module rxf_pick #(
  parameter int NUM_OBJ = 16
) (
  input  logic               req,
  input  logic [NUM_OBJ-1:0] vld,
  input  logic [NUM_OBJ-1:0] eob,
  input  logic [NUM_OBJ-1:0] acc,
  input  logic [NUM_OBJ-1:0] nd,
  output logic [NUM_OBJ-1:0] wr_vec,
  output logic               lost
);
  logic               open;
  logic               found;
  logic [NUM_OBJ-1:0] free_vec;
  logic [NUM_OBJ-1:0] ovr_vec;

  // Walk upward; the first valid chain-end object closes the search.
  always_comb begin
    open     = 1'b1;
    found    = 1'b0;
    free_vec = '0;
    ovr_vec  = '0;
    for (int i = 0; i < NUM_OBJ; i++) begin
      if (open && vld[i]) begin
        if (acc[i] && !nd[i] && !found) begin
          found       = 1'b1;
          free_vec[i] = 1'b1;
        end
        if (eob[i]) begin
          open = 1'b0;
          if (acc[i] && !found) ovr_vec[i] = 1'b1;
        end
      end
    end
    wr_vec = '0;
    lost   = 1'b0;
    if (req) begin
      if (found) begin
        wr_vec = free_vec;
      end else begin
        wr_vec = ovr_vec;
        lost   = |ovr_vec;
      end
    end
  end
endmodule

// File: rtl/rxf_obj.sv
module rxf_obj
  import rxf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_en,
  input  rxf_cfg_t   cfg_in,
  input  rxf_frame_t frm_in,
  input  logic       wr_en,
  input  logic       wr_lost,
  input  logic       ack_en,
  output logic       acc,
  output logic       vld,
  output logic       eob,
  output logic       rxie,
  output logic       nd,
  output logic       ip,
  output logic       ml,
  output rxf_frame_t held
);
  rxf_cfg_t        cfg_q;
  logic            vld_q;
  logic            nd_q, ip_q, ml_q;
  logic            nd_d, ip_d, ml_d;
  rxf_frame_t      held_q, held_d;
  logic [ID_W-1:0] id_diff;

  // Flag and payload next state
  always_comb begin
    nd_d = nd_q;
    ip_d = ip_q;
    ml_d = ml_q;
    if (wr_en) begin
      nd_d = 1'b1;
      ip_d = 1'b1;
      ml_d = wr_lost;
    end else if (ack_en) begin
      nd_d = 1'b0;
      ip_d = 1'b0;
      ml_d = 1'b0;
    end
    held_d = frm_in;
    if (frm_in.rtr) held_d.data = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      nd_q  <= 1'b0;
      ip_q  <= 1'b0;
      ml_q  <= 1'b0;
    end else begin
      if (cfg_en) vld_q <= cfg_in.vld;
      nd_q <= nd_d;
      ip_q <= ip_d;
      ml_q <= ml_d;
    end
  end

  // Datapath storage without reset
  always_ff @(posedge clk) begin
    if (cfg_en) cfg_q  <= cfg_in;
    if (wr_en)  held_q <= held_d;
  end

  assign id_diff = frm_in.id ^ cfg_q.id;
  assign acc  = vld_q && (cfg_q.umask ? ((id_diff & cfg_q.mask) == '0)
                                      : ((id_diff == '0) && (frm_in.xtd == cfg_q.xtd)));
  assign vld  = vld_q;
  assign eob  = vld_q && cfg_q.eob;
  assign rxie = vld_q && cfg_q.rxie;
  assign nd   = nd_q;
  assign ip   = ip_q;
  assign ml   = ml_q;
  assign held = held_q;
endmodule

// File: rtl/rxf_fifo.sv
module rxf_fifo
  import rxf_pkg::*;
#(
  parameter int NUM_OBJ = 16,
  localparam int IDX_W  = $clog2(NUM_OBJ)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [IDX_W-1:0]   cfg_sel,
  input  logic               cfg_vld,
  input  logic               cfg_eob,
  input  logic               cfg_rxie,
  input  logic               cfg_umask,
  input  logic               cfg_xtd,
  input  logic [ID_W-1:0]    cfg_id,
  input  logic [ID_W-1:0]    cfg_mask,
  input  logic               frm_valid,
  input  logic [ID_W-1:0]    frm_id,
  input  logic               frm_xtd,
  input  logic               frm_rtr,
  input  logic [DLC_W-1:0]   frm_dlc,
  input  logic [DATA_W-1:0]  frm_data,
  input  logic               ack_we,
  input  logic [IDX_W-1:0]   ack_sel,
  input  logic [IDX_W-1:0]   rd_sel,
  output logic [ID_W-1:0]    rd_id,
  output logic               rd_xtd,
  output logic               rd_rtr,
  output logic [DLC_W-1:0]   rd_dlc,
  output logic [DATA_W-1:0]  rd_data,
  output logic [NUM_OBJ-1:0] newdat_map,
  output logic [NUM_OBJ-1:0] intpnd_map,
  output logic [NUM_OBJ-1:0] msglost_map,
  output logic               rx_irq
);
  rxf_cfg_t           cfg_w;
  rxf_frame_t         frm_w;
  rxf_frame_t         held_arr [NUM_OBJ];
  rxf_frame_t         rd_frm;
  logic [NUM_OBJ-1:0] vld_v, eob_v, acc_v, nd_v, ip_v, ml_v, rxie_v, wr_v;
  logic               wr_lost;

  assign cfg_w = '{vld: cfg_vld, eob: cfg_eob, rxie: cfg_rxie, umask: cfg_umask,
                   xtd: cfg_xtd, id: cfg_id, mask: cfg_mask};
  assign frm_w = '{id: frm_id, xtd: frm_xtd, rtr: frm_rtr, dlc: frm_dlc, data: frm_data};

  rxf_pick #(.NUM_OBJ(NUM_OBJ)) pick_i (
    .req    (frm_valid),
    .vld    (vld_v),
    .eob    (eob_v),
    .acc    (acc_v),
    .nd     (nd_v),
    .wr_vec (wr_v),
    .lost   (wr_lost)
  );

  for (genvar g = 0; g < NUM_OBJ; g++) begin : g_obj
    rxf_obj obj_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .cfg_en  (cfg_we && (cfg_sel == IDX_W'(g))),
      .cfg_in  (cfg_w),
      .frm_in  (frm_w),
      .wr_en   (wr_v[g]),
      .wr_lost (wr_lost),
      .ack_en  (ack_we && (ack_sel == IDX_W'(g))),
      .acc     (acc_v[g]),
      .vld     (vld_v[g]),
      .eob     (eob_v[g]),
      .rxie    (rxie_v[g]),
      .nd      (nd_v[g]),
      .ip      (ip_v[g]),
      .ml      (ml_v[g]),
      .held    (held_arr[g])
    );
  end

  assign rd_frm      = held_arr[rd_sel];
  assign rd_id       = rd_frm.id;
  assign rd_xtd      = rd_frm.xtd;
  assign rd_rtr      = rd_frm.rtr;
  assign rd_dlc      = rd_frm.dlc;
  assign rd_data     = rd_frm.data;
  assign newdat_map  = nd_v;
  assign intpnd_map  = ip_v;
  assign msglost_map = ml_v;
  assign rx_irq      = |(ip_v & rxie_v);
endmodule

// File: rtl/rxf_fifo_chk.sv
module rxf_fifo_chk #(
  parameter int NUM_OBJ = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               frm_valid,
  input logic               ack_we,
  input logic [NUM_OBJ-1:0] newdat_map,
  input logic [NUM_OBJ-1:0] intpnd_map,
  input logic [NUM_OBJ-1:0] msglost_map,
  input logic               rx_irq
);
  // R2
  one_fill_per_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(newdat_map & ~$past(newdat_map)) <= 1);

  // R2
  fill_needs_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((newdat_map & ~$past(newdat_map)) != '0) |-> $past(frm_valid));

  // R11
  idle_keeps_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!frm_valid && !ack_we) |=> $stable(newdat_map));

  // R4
  lost_implies_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msglost_map & ~newdat_map) == '0);

  // R9
  pend_tracks_new_chk: assert property (@(posedge clk) disable iff (!rst_n)
    intpnd_map == newdat_map);

  // R10
  irq_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> (intpnd_map != '0));
endmodule

bind rxf_fifo rxf_fifo_chk #(.NUM_OBJ(NUM_OBJ)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .frm_valid   (frm_valid),
  .ack_we      (ack_we),
  .newdat_map  (newdat_map),
  .intpnd_map  (intpnd_map),
  .msglost_map (msglost_map),
  .rx_irq      (rx_irq)
);

// File: tb/rxf_fifo_tb_top.sv
`timescale 1ns/1ps
module rxf_fifo_tb_top;
  localparam int N  = 16;
  localparam int IW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_we, cfg_vld, cfg_eob, cfg_rxie, cfg_umask, cfg_xtd;
  logic [IW-1:0] cfg_sel;
  logic [28:0]   cfg_id, cfg_mask;
  logic          frm_valid, frm_xtd, frm_rtr;
  logic [28:0]   frm_id;
  logic [3:0]    frm_dlc;
  logic [63:0]   frm_data;
  logic          ack_we;
  logic [IW-1:0] ack_sel;
  logic [IW-1:0] rd_sel = '0;
  logic [28:0]   rd_id;
  logic          rd_xtd, rd_rtr;
  logic [3:0]    rd_dlc;
  logic [63:0]   rd_data;
  logic [N-1:0]  newdat_map, intpnd_map, msglost_map;
  logic          rx_irq;

  always #2.5 clk = ~clk;

  rxf_fifo #(.NUM_OBJ(N)) dut_i (.*);

  typedef struct {
    int          due;
    string       tag;
    logic [N-1:0] nd;
    logic [N-1:0] ml;
    logic        irq;
    bit          chk;
    int          obj;
    logic [28:0] id;
    logic        xtd;
    logic        rtr;
    logic [3:0]  dlc;
    logic [63:0] data;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   m_nd[N], m_ml[N], m_ie[N];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [63:0] pat(int k);
    return {8{8'(k * 17 + 3)}} ^ 64'h0f1e_2d3c_4b5a_6978;
  endfunction

  task automatic cmp(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic push(string tag, bit chk, int obj, logic [28:0] id, logic xtd,
                      logic rtr, logic [3:0] dlc, logic [63:0] data);
    exp_t e;
    e.due = cyc + 1; e.tag = tag; e.chk = chk; e.obj = obj;
    e.id = id; e.xtd = xtd; e.rtr = rtr; e.dlc = dlc; e.data = data;
    e.irq = 1'b0;
    for (int i = 0; i < N; i++) begin
      e.nd[i] = m_nd[i];
      e.ml[i] = m_ml[i];
      if (m_nd[i] && m_ie[i]) e.irq = 1'b1;
    end
    q.push_back(e);
  endtask

  // Monitor: pops items due this cycle, selects the object, samples mid-cycle
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0 && q[0].due <= cyc) begin
        exp_t e;
        e = q.pop_front();
        rd_sel = IW'(e.obj);
        #0.1;
        cmp(e.tag, "newdat_map R7", 64'(newdat_map), 64'(e.nd));
        cmp(e.tag, "intpnd_map", 64'(intpnd_map), 64'(e.nd));
        cmp(e.tag, "msglost_map", 64'(msglost_map), 64'(e.ml));
        cmp(e.tag, "rx_irq R10", 64'(rx_irq), 64'(e.irq));
        if (e.chk) begin
          cmp(e.tag, "rd_id", 64'(rd_id), 64'(e.id));
          cmp(e.tag, "rd_xtd", 64'(rd_xtd), 64'(e.xtd));
          cmp(e.tag, "rd_rtr", 64'(rd_rtr), 64'(e.rtr));
          cmp(e.tag, "rd_dlc", 64'(rd_dlc), 64'(e.dlc));
          cmp(e.tag, "rd_data", rd_data, e.data);
        end
      end
    end
  end

  task automatic begin_op();
    @(posedge clk);
    #1;
    cfg_we = 1'b0; frm_valid = 1'b0; ack_we = 1'b0;
  endtask

  task automatic do_cfg(int i, bit v, bit e, bit ie, bit um, bit x,
                        logic [28:0] id, logic [28:0] mk, string tag);
    begin_op();
    cfg_we = 1'b1; cfg_sel = IW'(i); cfg_vld = v; cfg_eob = e; cfg_rxie = ie;
    cfg_umask = um; cfg_xtd = x; cfg_id = id; cfg_mask = mk;
    m_ie[i] = v && ie;
    push(tag, 0, 0, '0, 0, 0, '0, '0);
  endtask

  task automatic do_ack(int i, string tag);
    begin_op();
    ack_we = 1'b1; ack_sel = IW'(i);
    m_nd[i] = 0; m_ml[i] = 0;
    push(tag, 0, 0, '0, 0, 0, '0, '0);
  endtask

  // exp_obj < 0 means the frame is expected to be dropped
  task automatic do_frame(logic [28:0] id, bit x, bit r, logic [3:0] dlc,
                          logic [63:0] d, int exp_obj, bit lost, string tag);
    begin_op();
    frm_valid = 1'b1; frm_id = id; frm_xtd = x; frm_rtr = r;
    frm_dlc = dlc; frm_data = d;
    if (exp_obj >= 0) begin
      m_nd[exp_obj] = 1; m_ml[exp_obj] = lost;
      push(tag, 1, exp_obj, id, x, r, dlc, r ? 64'h0 : d);
    end else begin
      push(tag, 0, 0, '0, 0, 0, '0, '0);
    end
  endtask

  initial begin
    #500000;
    n_bad++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cfg_we = 0; cfg_sel = '0; cfg_vld = 0; cfg_eob = 0; cfg_rxie = 0;
    cfg_umask = 0; cfg_xtd = 0; cfg_id = '0; cfg_mask = '0;
    frm_valid = 0; frm_id = '0; frm_xtd = 0; frm_rtr = 0; frm_dlc = '0; frm_data = '0;
    ack_we = 0; ack_sel = '0;
    for (int i = 0; i < N; i++) begin m_nd[i] = 0; m_ml[i] = 0; m_ie[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    push("R1 reset", 0, 0, '0, 0, 0, '0, '0);

    for (int i = 0; i < N; i++) do_cfg(i, 1, i == N - 1, 1, 1, 0, '0, '0, "R6 open cfg");

    do_frame(29'h111, 0, 0, 4'd8, pat(1), 0, 0, "R2 first frame");
    do_frame(29'h1abc_def0, 1, 0, 4'd8, pat(2), 1, 0, "R2 R7 second frame");
    do_ack(0, "R9 ack low");
    do_frame(29'h333, 0, 0, 4'd6, pat(3), 0, 0, "R9 reuse low object");
    do_frame(29'h444, 0, 1, 4'd4, pat(4), 2, 0, "R8 remote frame");
    for (int k = 3; k < N; k++)
      do_frame(29'(k + 'h500), 0, 0, 4'(k % 9), pat(k), k, 0, "R2 fill");
    do_frame(29'h6aa, 0, 0, 4'd8, pat(40), 15, 1, "R4 overwrite chain end");

    for (int i = 0; i < N; i++) do_ack(i, "R9 ack all");
    do_cfg(2, 0, 0, 1, 1, 0, '0, '0, "R5 invalidate");
    do_frame(29'h010, 0, 0, 4'd1, pat(5), 0, 0, "R5 skip a");
    do_frame(29'h020, 0, 0, 4'd2, pat(6), 1, 0, "R5 skip b");
    do_frame(29'h030, 0, 0, 4'd3, pat(7), 3, 0, "R5 skip invalid object");

    do_cfg(4, 1, 1, 1, 1, 0, '0, '0, "R3 early chain end");
    do_frame(29'h040, 0, 0, 4'd4, pat(8), 4, 0, "R3 last in chain");
    do_frame(29'h050, 0, 0, 4'd5, pat(9), 4, 1, "R3 stop at chain end");

    do_cfg(4, 1, 1, 1, 0, 0, 29'h7ff, '0, "R6 exact cfg");
    do_frame(29'h005, 0, 0, 4'd1, pat(10), -1, 0, "R11 drop");

    do_ack(0, "R9 ack");
    do_ack(1, "R9 ack");
    do_cfg(0, 1, 0, 1, 1, 0, 29'h123, 29'h7ff, "R6 mask cfg");
    do_frame(29'h055, 0, 0, 4'd2, pat(11), 1, 0, "R6 mask reject");
    do_frame(29'h1f123, 1, 0, 4'd3, pat(12), 0, 0, "R6 masked accept");
    do_ack(4, "R9 ack");
    do_frame(29'h7ff, 1, 0, 4'd1, pat(13), -1, 0, "R6 R11 format mismatch");
    do_frame(29'h7ff, 0, 0, 4'd7, pat(14), 4, 0, "R6 exact match");

    do_cfg(0, 1, 0, 0, 1, 0, 29'h123, 29'h7ff, "R10 mask irq");
    do_cfg(1, 1, 0, 0, 1, 0, '0, '0, "R10 mask irq");
    do_cfg(3, 1, 0, 0, 1, 0, '0, '0, "R10 mask irq");
    do_cfg(4, 1, 1, 0, 0, 0, 29'h7ff, '0, "R10 irq low with pending");
    do_ack(4, "R9 R10 ack");

    begin_op();
    wait (q.size() == 0);
    repeat (2) @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule